// File: doc/BRIEF.md
# Display frame signature monitor

This block watches a pixel stream and checks each frame for corruption. For every frame it is told to check, it computes a CRC-32 signature over the pixels and compares it with a reference value that software has programmed. A pixel timing source supplies four things: a frame-start strobe, a frame-end strobe, a pixel-valid strobe and the pixel's column and row. There are two signature lanes. Lane A covers a programmable rectangle, or the whole frame when the rectangle is switched off. Lane B always covers the whole frame.

Software programs a working set of registers. It then writes the trigger register, choosing either a one-shot check or a check on every frame. The working set is copied into a shadow set at the next frame start, so a check never sees a half-written configuration. Frames whose enabled signatures differ from their references are counted. When that count rises above a threshold, a sticky status flag is set. Three status flags can each drive the single interrupt line through their own enable bits.

A plain register port stands in for the system bus. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `fsig_monitor`

## Requirements
- R1: The working registers read back exactly what was written. These are: window columns at 0x30 (start in bits 11:0, end in bits 27:16), window rows at 0x34 (same layout), reference A at 0x38, reference B at 0x3C, error threshold at 0x40 (bits 7:0) and control at 0x50 (bit 0 lane A enable, bit 8 lane B enable, bit 16 window enable). The trigger register at 0x54 reads back its mode in bits 9:8, and its go bit (bit 0) always reads 0.
- R2: Writing 0x54 with go=1 and mode 00 requests one check. The pending flag reads 1 until the next frame start. That frame is then checked, and no later frame is checked without a new trigger.
- R3: Mode 01 with go=1 starts checking every frame. The configuration is copied only at the first frame start after the trigger. A later write with mode 00 and go=1 cancels the repetition: the next frame is checked once and the frames after it are not.
- R4: A write to 0x54 with mode 10 or 11, or with go=0, requests nothing. No frame is checked and no copy happens.
- R5: A signature is a CRC-32 with generator 0x04C11DB7 and an initial value of all ones, with no bit reflection and no final inversion. It is fed the 24 pixel bits MSB first, for every valid pixel between frame start and frame end, in stream order. Lane A takes only pixels whose column and row lie inside the window, bounds included. Results are latched at frame end, into 0x64 (A) and 0x68 (B).
- R6: When the window enable is 0, lane A covers the whole frame. A lane whose enable is 0 leaves its result register unchanged and takes no part in the comparison.
- R7: Register writes made after the copy do not affect a checked frame. They take effect only at the next triggered copy.
- R8: The interrupt status register at 0x5C has three flags: bit 0 (error count exceeded), bit 1 (configuration copied) and bit 2 (result valid). Each flag sets on its event whether or not it is enabled. Writing 1 to a flag clears it. Writing 0 leaves it unchanged.
- R9: The error-frame count at 0x6C is cleared by every copy. It rises by one for each checked frame in which an enabled lane differs from its reference. Bit 0 of 0x5C is set when the count goes from equal to the threshold to above it. Reaching the threshold alone does not set it.
- R10: The `irq` output is high whenever any status flag is set together with its enable bit at 0x58 (same bit positions). It stays high until software clears the flag or the enable.
- R11: The status register at 0x60 is read-only. Bit 0 is pending, bit 1 is active (the current frame is being checked), bit 8 is the lane A mismatch of the last check and bit 9 is the lane B mismatch of the last check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| pix_sof | input | 1 | Frame start strobe (never with a valid pixel) |
| pix_eof | input | 1 | Frame end strobe (may carry the last pixel) |
| pix_valid | input | 1 | Pixel qualifier |
| pix_x | input | 12 | Pixel column |
| pix_y | input | 12 | Pixel row |
| pix_data | input | 24 | Pixel value |
| irq | output | 1 | Level interrupt |

## Verification
A fault in the trigger sequencer shows up one frame later. The symptom is either a missing or extra result-valid flag, or a configuration-copied flag in the wrong frame, or a pending bit that never clears. A wrong CRC step or window bound corrupts the result register as soon as the frame-end strobe arrives. Sweeping many window rectangles over fixed frames catches this on the first rectangle whose edge is involved. A threshold comparison that is off by one moves the exceeded flag and the interrupt by exactly one frame, so the bench reads them after the frame that reaches the threshold and again after the frame that exceeds it.

// File: rtl/fsig_pkg.sv
package fsig_pkg;
  localparam logic [7:0] A_WINX = 8'h30;
  localparam logic [7:0] A_WINY = 8'h34;
  localparam logic [7:0] A_REFA = 8'h38;
  localparam logic [7:0] A_REFB = 8'h3C;
  localparam logic [7:0] A_THR  = 8'h40;
  localparam logic [7:0] A_CTRL = 8'h50;
  localparam logic [7:0] A_TRIG = 8'h54;
  localparam logic [7:0] A_IEN  = 8'h58;
  localparam logic [7:0] A_ISTS = 8'h5C;
  localparam logic [7:0] A_STAT = 8'h60;
  localparam logic [7:0] A_RESA = 8'h64;
  localparam logic [7:0] A_RESB = 8'h68;
  localparam logic [7:0] A_ECNT = 8'h6C;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // status flag positions
  localparam int EV_EXCEED = 0;
  localparam int EV_COPY   = 1;
  localparam int EV_RESULT = 2;
  localparam int N_EV      = 3;
  localparam int N_LANE    = 2;

  typedef enum logic [1:0] {
    TM_ONCE   = 2'b00,
    TM_CYCLIC = 2'b01,
    TM_RSV2   = 2'b10,
    TM_RSV3   = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/fsig_crc.sv
module fsig_crc #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [PIX_W-1:0] pix,
  output logic [31:0]      crc_now
);
  function automatic logic [31:0] crc_fold(input logic [31:0] c, input logic [PIX_W-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = PIX_W - 1; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ fsig_pkg::CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  logic [31:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '1;
    else if (clr)  acc <= '1;
    else if (take) acc <= crc_fold(acc, pix);
  end

  // includes a pixel that arrives together with frame end
  assign crc_now = take ? crc_fold(acc, pix) : acc;

  // R5
  seed_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !take) |=> (crc_now == 32'hFFFFFFFF) || take);
endmodule

// File: rtl/fsig_seq.sv
module fsig_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_go,
  input  logic [1:0] trig_mode,
  input  logic       sof,
  input  logic       eof,
  output logic       run,
  output logic       pending,
  output logic       copy_evt,
  output logic       done_evt
);
  import fsig_pkg::*;

  logic cyclic, pend_cyc, trig_ok;

  assign trig_ok  = trig_go && (trig_mode == TM_ONCE || trig_mode == TM_CYCLIC);
  assign copy_evt = sof && pending;
  assign done_evt = eof && run && !sof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; pending <= 1'b0; cyclic <= 1'b0; pend_cyc <= 1'b0;
    end else begin
      if (sof) begin
        run <= pending || cyclic;
        if (pending) begin
          cyclic  <= pend_cyc;
          pending <= 1'b0;
        end
      end else if (done_evt) begin
        run <= 1'b0;
      end
      if (trig_ok) begin
        pending  <= 1'b1;
        pend_cyc <= (trig_mode == TM_CYCLIC);
        if (trig_mode == TM_ONCE) cyclic <= 1'b0;
      end
    end
  end

  // R2
  pending_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && pending && !trig_go) |=> (!pending && run));
  // R4
  reserved_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_go && trig_mode[1] && !sof) |=> (pending == $past(pending)));
  // R3
  cyclic_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && cyclic) |=> run);
endmodule

// File: rtl/fsig_errcnt.sv
module fsig_errcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bump,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             exceed_evt
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  assign exceed_evt = bump && (cnt <= thr) && (sat_inc(cnt) > thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (bump) cnt <= sat_inc(cnt);
  end

  // R9
  exceed_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exceed_evt && !clr) |=> (cnt > $past(thr)));
  // R9
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/fsig_monitor.sv
module fsig_monitor #(
  parameter int CW    = 12,
  parameter int PIX_W = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             pix_sof,
  input  logic             pix_eof,
  input  logic             pix_valid,
  input  logic [CW-1:0]    pix_x,
  input  logic [CW-1:0]    pix_y,
  input  logic [PIX_W-1:0] pix_data,
  output logic             irq
);
  import fsig_pkg::*;

  // working configuration
  logic [CW-1:0]    w_xs, w_xe, w_ys, w_ye;
  logic [31:0]      w_refa, w_refb;
  logic [CNT_W-1:0] w_thr;
  logic             w_en_a, w_en_b, w_en_w;
  // shadow configuration
  logic [CW-1:0]    s_xs, s_xe, s_ys, s_ye;
  logic [31:0]      s_refa, s_refb;
  logic [CNT_W-1:0] s_thr;
  logic             s_en_a, s_en_b, s_en_w;

  logic [N_EV-1:0]  ien, ists, ev;
  logic [1:0]       tmode;
  logic [31:0]      res_a, res_b;
  logic             dif_a, dif_b;

  logic             run, pending, copy_evt, done_evt, exceed_evt;
  logic             in_win, diff_a, diff_b, trig_go;
  logic [CNT_W-1:0] err_cnt;
  logic [N_LANE-1:0] take_v;
  logic [31:0]      crc_v [N_LANE];

  function automatic logic in_span(input logic [CW-1:0] v, input logic [CW-1:0] lo, input logic [CW-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  assign trig_go = reg_we && (reg_addr == A_TRIG) && reg_wdata[0];
  assign in_win  = !s_en_w || (in_span(pix_x, s_xs, s_xe) && in_span(pix_y, s_ys, s_ye));
  assign take_v  = {pix_valid, pix_valid && in_win};

  fsig_seq u_seq (
    .clk, .rst_n, .trig_go, .trig_mode(reg_wdata[9:8]),
    .sof(pix_sof), .eof(pix_eof),
    .run, .pending, .copy_evt, .done_evt
  );

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    fsig_crc #(.PIX_W(PIX_W)) u_crc (
      .clk, .rst_n, .clr(pix_sof), .take(take_v[g]), .pix(pix_data), .crc_now(crc_v[g])
    );
  end

  assign diff_a = s_en_a && (crc_v[0] != s_refa);
  assign diff_b = s_en_b && (crc_v[1] != s_refb);

  fsig_errcnt #(.CNT_W(CNT_W)) u_err (
    .clk, .rst_n, .clr(copy_evt), .bump(done_evt && (diff_a || diff_b)),
    .thr(s_thr), .cnt(err_cnt), .exceed_evt
  );

  always_comb begin
    ev = '0;
    ev[EV_EXCEED] = exceed_evt;
    ev[EV_COPY]   = copy_evt;
    ev[EV_RESULT] = done_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_xs <= '0; w_xe <= '0; w_ys <= '0; w_ye <= '0;
      w_refa <= '0; w_refb <= '0; w_thr <= '0;
      w_en_a <= 1'b0; w_en_b <= 1'b0; w_en_w <= 1'b0;
      ien <= '0; tmode <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_WINX: begin w_xs <= reg_wdata[0+:CW]; w_xe <= reg_wdata[16+:CW]; end
        A_WINY: begin w_ys <= reg_wdata[0+:CW]; w_ye <= reg_wdata[16+:CW]; end
        A_REFA: w_refa <= reg_wdata;
        A_REFB: w_refb <= reg_wdata;
        A_THR:  w_thr  <= reg_wdata[CNT_W-1:0];
        A_CTRL: begin w_en_a <= reg_wdata[0]; w_en_b <= reg_wdata[8]; w_en_w <= reg_wdata[16]; end
        A_TRIG: tmode <= reg_wdata[9:8];
        A_IEN:  ien <= reg_wdata[N_EV-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_xs <= '0; s_xe <= '0; s_ys <= '0; s_ye <= '0;
      s_refa <= '0; s_refb <= '0; s_thr <= '0;
      s_en_a <= 1'b0; s_en_b <= 1'b0; s_en_w <= 1'b0;
    end else if (copy_evt) begin
      s_xs <= w_xs; s_xe <= w_xe; s_ys <= w_ys; s_ye <= w_ye;
      s_refa <= w_refa; s_refb <= w_refb; s_thr <= w_thr;
      s_en_a <= w_en_a; s_en_b <= w_en_b; s_en_w <= w_en_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_a <= '0; res_b <= '0; dif_a <= 1'b0; dif_b <= 1'b0; ists <= '0;
    end else begin
      if (done_evt) begin
        if (s_en_a) res_a <= crc_v[0];
        if (s_en_b) res_b <= crc_v[1];
        dif_a <= diff_a;
        dif_b <= diff_b;
      end
      // a new event wins over a clear in the same cycle
      ists <= (ists & ~((reg_we && reg_addr == A_ISTS) ? reg_wdata[N_EV-1:0] : '0)) | ev;
    end
  end

  assign irq = |(ists & ien);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_WINX: begin reg_rdata[0+:CW] = w_xs; reg_rdata[16+:CW] = w_xe; end
      A_WINY: begin reg_rdata[0+:CW] = w_ys; reg_rdata[16+:CW] = w_ye; end
      A_REFA: reg_rdata = w_refa;
      A_REFB: reg_rdata = w_refb;
      A_THR:  reg_rdata[CNT_W-1:0] = w_thr;
      A_CTRL: begin reg_rdata[0] = w_en_a; reg_rdata[8] = w_en_b; reg_rdata[16] = w_en_w; end
      A_TRIG: reg_rdata[9:8] = tmode;
      A_IEN:  reg_rdata[N_EV-1:0] = ien;
      A_ISTS: reg_rdata[N_EV-1:0] = ists;
      A_STAT: begin reg_rdata[0] = pending; reg_rdata[1] = run; reg_rdata[8] = dif_a; reg_rdata[9] = dif_b; end
      A_RESA: reg_rdata = res_a;
      A_RESB: reg_rdata = res_b;
      A_ECNT: reg_rdata[CNT_W-1:0] = err_cnt;
      default: ;
    endcase
  end

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_we && (reg_addr == A_ISTS || reg_addr == A_IEN))) |=> irq);
  // R8
  result_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ists[EV_RESULT] && !(reg_we && reg_addr == A_ISTS && reg_wdata[EV_RESULT])) |=> ists[EV_RESULT]);
  // R7
  shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pix_sof) |=> ($stable(s_refa) && $stable(s_xs) && $stable(s_xe)));
endmodule

// File: tb/fsig_monitor_test.sv
module fsig_monitor_test;
  localparam int W = 6;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_sof = 1'b0, pix_eof = 1'b0, pix_valid = 1'b0;
  logic [11:0] pix_x = '0, pix_y = '0;
  logic [23:0] pix_data = '0;
  logic        irq;
  logic [31:0] probe;
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fsig_monitor uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  function automatic logic [23:0] pv(input int x, input int y, input int seed);
    return 24'((x * 37 + y * 101 + seed * 7919) ^ (seed * 65539));
  endfunction

  // bytewise long division, MSB first
  function automatic logic [31:0] m_step(input logic [31:0] c0, input logic [23:0] d);
    logic [31:0] c;
    c = c0;
    for (int b = 2; b >= 0; b--) begin
      c = c ^ {d[b*8+:8], 24'h0};
      for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] m_sig(input int seed, input bit win, input int xs, input int xe,
                                        input int ys, input int ye);
    logic [31:0] c;
    c = '1;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        if (!win || (x >= xs && x <= xe && y >= ys && y <= ye)) c = m_step(c, pv(x, y, seed));
    return c;
  endfunction

  task automatic frame(input int seed);
    @(negedge clk); pix_sof = 1'b1;
    @(negedge clk); pix_sof = 1'b0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        pix_valid = 1'b1; pix_x = 12'(x); pix_y = 12'(y); pix_data = pv(x, y, seed);
        if (x == 0 && y == 1) begin #1; probe = reg_rdata; end
        @(negedge clk);
      end
    pix_valid = 1'b0; pix_eof = 1'b1;
    @(negedge clk); pix_eof = 1'b0;
  endtask

  task automatic set_win(input int xs, input int xe, input int ys, input int ye);
    wr(8'h30, {16'(xe), 16'(xs)});
    wr(8'h34, {16'(ye), 16'(ys)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rdchk("R8 reset flags", 8'h5C, 0);
    rdchk("R11 reset status", 8'h60, 0);
    rdchk("R9 reset count", 8'h6C, 0);
    chk("R10 reset irq", 32'(irq), 0);

    // R1 readback
    set_win(1, 4, 1, 2);
    rdchk("R1 winx", 8'h30, 32'h0004_0001);
    rdchk("R1 winy", 8'h34, 32'h0002_0001);
    wr(8'h38, 32'hDEAD_BEEF); rdchk("R1 refa", 8'h38, 32'hDEAD_BEEF);
    wr(8'h40, 32'hFFFF_FF2A); rdchk("R1 thr", 8'h40, 32'h2A);
    wr(8'h50, 32'hFFFF_FFFF); rdchk("R1 ctrl", 8'h50, 32'h0001_0101);
    wr(8'h54, 32'h0000_0100); rdchk("R1 trig readback", 8'h54, 32'h100);
    rdchk("R4 go=0 no pending", 8'h60, 0);

    // R4 reserved modes
    wr(8'h54, 32'h201); wr(8'h54, 32'h301);
    rdchk("R4 reserved no pending", 8'h60, 0);
    frame(0);
    rdchk("R4 reserved no copy or result", 8'h5C, 0);

    // R2 single
    wr(8'h38, m_sig(1, 1, 1, 4, 1, 2));
    wr(8'h3C, m_sig(1, 0, 0, 0, 0, 0));
    wr(8'h40, 0);
    wr(8'h54, 32'h001);
    rdchk("R2 pending", 8'h60, 32'h1);
    wr(8'h60, 8'hAB);
    reg_addr = 8'h60;
    frame(1);
    chk("R11 active mid-frame", probe, 32'h2);
    rdchk("R8 copy+result flags", 8'h5C, 32'h6);
    rdchk("R5 lane A window", 8'h64, m_sig(1, 1, 1, 4, 1, 2));
    rdchk("R6 lane B full", 8'h68, m_sig(1, 0, 0, 0, 0, 0));
    rdchk("R11 idle after", 8'h60, 0);
    rdchk("R9 no error", 8'h6C, 0);
    wr(8'h5C, 0); rdchk("R8 write 0 keeps", 8'h5C, 32'h6);
    wr(8'h5C, 7); rdchk("R8 write 1 clears", 8'h5C, 0);
    frame(2);
    rdchk("R2 no second run flags", 8'h5C, 0);
    rdchk("R2 result held", 8'h64, m_sig(1, 1, 1, 4, 1, 2));

    // R5 window sweep
    wr(8'h40, 32'hFF);
    for (int xs = 0; xs < W; xs++)
      for (int xe = xs; xe < W; xe++) begin
        int ys, ye;
        ys = (xs + xe) % H; ye = (ys + xe) % H; if (ye < ys) ye = H - 1;
        set_win(xs, xe, ys, ye);
        wr(8'h54, 32'h001);
        frame(10 + xs * 8 + xe);
        rdchk("R5 sweep", 8'h64, m_sig(10 + xs * 8 + xe, 1, xs, xe, ys, ye));
      end

    // R6 window off, then lane A off
    wr(8'h50, 32'h0000_0101); wr(8'h54, 32'h001); frame(50);
    rdchk("R6 window off A", 8'h64, m_sig(50, 0, 0, 0, 0, 0));
    wr(8'h50, 32'h0000_0100); wr(8'h54, 32'h001); frame(51);
    rdchk("R6 lane A disabled keeps", 8'h64, m_sig(50, 0, 0, 0, 0, 0));
    rdchk("R6 lane B updates", 8'h68, m_sig(51, 0, 0, 0, 0, 0));

    // R3 / R7 cyclic
    wr(8'h50, 32'h0001_0101); set_win(0, 2, 0, 1);
    wr(8'h54, 32'h101); frame(60);
    rdchk("R3 first cyclic copy", 8'h5C, 32'h6);
    wr(8'h5C, 7);
    set_win(3, 5, 2, 3);
    frame(61);
    rdchk("R7 old window still used", 8'h64, m_sig(61, 1, 0, 2, 0, 1));
    rdchk("R3 repeat without copy", 8'h5C, 32'h4);
    wr(8'h5C, 7);
    wr(8'h54, 32'h001); frame(62);
    rdchk("R7 new window after copy", 8'h64, m_sig(62, 1, 3, 5, 2, 3));
    rdchk("R3 cancel frame checked", 8'h5C, 32'h6);
    wr(8'h5C, 7);
    keep = m_sig(62, 1, 3, 5, 2, 3);
    frame(63);
    rdchk("R3 cyclic cancelled", 8'h5C, 0);
    rdchk("R3 result unchanged", 8'h64, keep);

    // R9 / R10 threshold
    wr(8'h50, 32'h0001_0001); wr(8'h38, 0); wr(8'h40, 2); wr(8'h58, 1);
    wr(8'h54, 32'h101);
    frame(70); frame(71);
    rdchk("R9 count at threshold", 8'h6C, 2);
    rdchk("R9 equal does not fire", 8'h5C, 32'h6);
    chk("R10 irq low", 32'(irq), 0);
    frame(72);
    rdchk("R9 count above", 8'h6C, 3);
    rdchk("R9 exceed flag", 8'h5C, 32'h7);
    rdchk("R11 diff A bit", 8'h60, 32'h100);
    chk("R10 irq high", 32'(irq), 1);
    wr(8'h5C, 32'h6);
    chk("R10 irq held", 32'(irq), 1);
    wr(8'h54, 32'h001);
    wr(8'h5C, 32'h1);
    chk("R10 irq cleared", 32'(irq), 0);
    frame(73);
    rdchk("R9 copy clears count", 8'h6C, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule